// File: doc/BRIEF.md
# Audio Sample-Pair Receive FIFO

This block buffers left/right audio sample pairs arriving from a serial deserializer and hands them to a processor through 32-bit reads. Each incoming pair enters the buffer in one cycle. A read port then unpacks the pairs in one of four ways. The first returns the left and right samples on alternate reads. The second packs both channels into one word as 16-bit halves. The third packs both channels as bytes. The fourth keeps only the left channel.

Occupancy is reported as a level in sample units, and a stored pair always counts as two. A service request tells the consumer when the level is above a programmable even threshold. Two sticky flags are kept. One records a pair that was dropped because the buffer was full. The other records a read made while the buffer held nothing.

Top module: `pair_rx_fifo`

## Requirements
- R1: `level_o` equals twice the number of stored pairs, minus one while a pair's left sample has already been read in alternating mode. Capacity is 8 pairs, so `level_o` never exceeds 16.
- R2: A pair presented while the buffer already holds 8 pairs is discarded, and `ovf_o` becomes 1 and stays 1 until reset.
- R3: With `mode_i`=0 (alternating), successive reads return the left sample and then the right sample of the head pair. Only the second read removes the pair. After a left-only read the level is odd.
- R4: With `mode_i`=1 (16-bit packed), `rd_data_o` holds left[15:0] in bits 15:0 and right[15:0] in bits 31:16. One read removes the pair.
- R5: With `mode_i`=2 (byte packed), `rd_data_o` holds left[7:0] in bits 7:0 and right[7:0] in bits 15:8, with bits 31:16 zero. One read removes the pair.
- R6: With `mode_i`=3 (single channel), `rd_data_o` is the left sample, and one read removes the whole pair, lowering the level by 2.
- R7: `req_o` is 1 exactly when `level_o` is strictly greater than the stored limit with its bit 0 taken as 0. A limit of 0 requests whenever any data is held, and a limit of 16 never requests.
- R8: A write through `lim_we_i` stores `lim_wdata_i`. `lim_rdata_o` returns bits 4:1 of the stored value, with bit 0 always 1.
- R9: A read while `level_o` is 0 does not change the level. `rd_data_o` is 0 whenever the buffer is empty, and such a read sets the sticky `rd_err_o`.
- R10: After reset the level is 0, `req_o`, `ovf_o` and `rd_err_o` are 0, `rd_data_o` is 0 and `lim_rdata_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Unpacking mode: 0 alternating, 1 16-bit packed, 2 byte packed, 3 single channel |
| wr_valid_i | input | 1 | Pair present from the deserializer this cycle |
| wr_left_i | input | 32 | Left sample of the incoming pair |
| wr_right_i | input | 32 | Right sample of the incoming pair |
| rd_en_i | input | 1 | Read strobe; `rd_data_o` of this cycle is the value read |
| rd_data_o | output | 32 | Unpacked read word for the head of the buffer |
| level_o | output | 5 | Occupancy in samples |
| lim_we_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | 5 | Limit write value |
| lim_rdata_o | output | 5 | Limit readback, bit 0 forced to 1 |
| req_o | output | 1 | Service request, level above limit |
| ovf_o | output | 1 | Sticky: a pair was dropped while full |
| rd_err_o | output | 1 | Sticky: a read found the buffer empty |

## Verification
The bench drives full-buffer writes that coincide with reads. A design that compared fullness after the pop would accept the pair and disagree with the reference queue. In alternating mode the bench reads half a pair and then checks the data, so a design that popped on the left read, or that failed to subtract the half sample, would show an even level or return the wrong channel. The limit is moved through 0, 16 and odd values. This catches a `>=` comparison or a request that honoured the forced low bit. Reads are also driven past empty, which exposes a design that moved the level or returned stale data.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  typedef enum logic [1:0] {
    MODE_ALT  = 2'd0,
    MODE_P16  = 2'd1,
    MODE_P8   = 2'd2,
    MODE_MONO = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/pair_store.sv
module pair_store #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     left_i,
  input  logic [W-1:0]     right_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_left_o,
  output logic [W-1:0]     head_right_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     left_mem  [DEPTH];
  logic [W-1:0]     right_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      left_mem[wr_ptr_q]  <= left_i;
      right_mem[wr_ptr_q] <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_left_o  = left_mem[rd_ptr_q];
  assign head_right_o = right_mem[rd_ptr_q];
  assign count_o      = cnt_q;
endmodule

// File: rtl/pair_unpack.sv
module pair_unpack
  import pfifo_pkg::*;
#(
  parameter int W = 32,
  localparam int F16 = W / 2,
  localparam int F8  = W / 4
) (
  input  rx_mode_e     mode_i,
  input  logic         empty_i,
  input  logic         half_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  output logic [W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (!empty_i) begin
      unique case (mode_i)
        MODE_ALT:  data_o = half_i ? right_i : left_i;
        MODE_P16:  data_o = {right_i[F16-1:0], left_i[F16-1:0]};
        MODE_P8:   data_o = {{(W-2*F8){1'b0}}, right_i[F8-1:0], left_i[F8-1:0]};
        MODE_MONO: data_o = left_i;
        default:   data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/req_gen.sv
module req_gen #(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [LVL_W-1:0] lim_wdata_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] lim_rdata_o,
  output logic             req_o
);
  // only the even part of the limit is held
  logic [LVL_W-2:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lim_q <= '0;
    else if (lim_we_i) lim_q <= lim_wdata_i[LVL_W-1:1];
  end

  assign lim_rdata_o = {lim_q, 1'b1};
  assign req_o       = (level_i > {lim_q, 1'b0});
endmodule

// File: rtl/pair_rx_fifo.sv
module pair_rx_fifo
  import pfifo_pkg::*;
#(
  parameter int PAIR_DEPTH = 8,
  parameter int SAMPLE_W   = 32,
  localparam int LVL_W = $clog2(2 * PAIR_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                wr_valid_i,
  input  logic [SAMPLE_W-1:0] wr_left_i,
  input  logic [SAMPLE_W-1:0] wr_right_i,
  input  logic                rd_en_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]    level_o,
  input  logic                lim_we_i,
  input  logic [LVL_W-1:0]    lim_wdata_i,
  output logic [LVL_W-1:0]    lim_rdata_o,
  output logic                req_o,
  output logic                ovf_o,
  output logic                rd_err_o
);
  localparam int CNT_W = $clog2(PAIR_DEPTH + 1);

  rx_mode_e            mode;
  logic                full, empty, push, pop, rd_hit, half_q, ovf_q, err_q;
  logic [CNT_W-1:0]    pair_cnt;
  logic [SAMPLE_W-1:0] head_l, head_r;

  assign mode   = rx_mode_e'(mode_i);
  assign push   = wr_valid_i && !full;
  assign rd_hit = rd_en_i && !empty;
  // alternating mode removes the pair only on the right-sample read
  assign pop    = rd_hit && ((mode != MODE_ALT) || half_q);

  pair_store #(.DEPTH(PAIR_DEPTH), .W(SAMPLE_W)) u_store (
    .clk_i, .rst_ni,
    .push_i(push), .left_i(wr_left_i), .right_i(wr_right_i),
    .pop_i(pop), .head_left_o(head_l), .head_right_o(head_r),
    .count_o(pair_cnt), .full_o(full), .empty_o(empty)
  );

  pair_unpack #(.W(SAMPLE_W)) u_unpack (
    .mode_i(mode), .empty_i(empty), .half_i(half_q),
    .left_i(head_l), .right_i(head_r), .data_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (rd_hit)                half_q <= (mode == MODE_ALT) && !half_q;
      if (wr_valid_i && full)    ovf_q  <= 1'b1;
      if (rd_en_i && empty)      err_q  <= 1'b1;
    end
  end

  assign level_o  = (LVL_W'(pair_cnt) << 1) - LVL_W'(half_q);
  assign ovf_o    = ovf_q;
  assign rd_err_o = err_q;

  req_gen #(.LVL_W(LVL_W)) u_req (
    .clk_i, .rst_ni,
    .lim_we_i, .lim_wdata_i, .level_i(level_o),
    .lim_rdata_o, .req_o
  );
endmodule

// File: rtl/pfifo_checker.sv
module pfifo_checker #(
  parameter int LVL_W    = 5,
  parameter int FULL_LVL = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             wr_valid_i,
  input logic             rd_en_i,
  input logic [31:0]      rd_data_o,
  input logic [LVL_W-1:0] level_o,
  input logic [LVL_W-1:0] lim_rdata_o,
  input logic             req_o,
  input logic             ovf_o,
  input logic             rd_err_o
);
  AST_LEVEL_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(FULL_LVL)); // R1

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R2

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LVL_W'(FULL_LVL) && wr_valid_i && !rd_en_i)
    |=> (level_o == LVL_W'(FULL_LVL) && ovf_o)); // R2

  AST_ALT_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && rd_en_i && !wr_valid_i && level_o != '0 && !level_o[0])
    |=> level_o[0]); // R3

  AST_MONO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && rd_en_i && !wr_valid_i && level_o != '0)
    |=> (level_o == $past(level_o) - LVL_W'(2))); // R6

  AST_NO_REQ_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_rdata_o[LVL_W-1:1] == (LVL_W-1)'(FULL_LVL / 2)) |-> !req_o); // R7

  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0 && rd_en_i && !wr_valid_i) |=> (level_o == '0 && rd_err_o)); // R9

  AST_EMPTY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (rd_data_o == '0)); // R9
endmodule

bind pair_rx_fifo pfifo_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .wr_valid_i(wr_valid_i),
  .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .level_o(level_o),
  .lim_rdata_o(lim_rdata_o), .req_o(req_o), .ovf_o(ovf_o), .rd_err_o(rd_err_o)
);

// File: tb/pair_rx_fifo_test.sv
module pair_rx_fifo_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [31:0] wr_left_i = '0, wr_right_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [4:0]  level_o;
  logic        lim_we_i = 1'b0;
  logic [4:0]  lim_wdata_i = '0;
  logic [4:0]  lim_rdata_o;
  logic        req_o, ovf_o, rd_err_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [63:0] q[$];
  bit          m_half, m_ovf, m_err;
  logic [4:0]  m_lim;

  always #4 clk = ~clk;

  pair_rx_fifo uut (
    .clk_i(clk), .rst_ni, .mode_i, .wr_valid_i, .wr_left_i, .wr_right_i,
    .rd_en_i, .rd_data_o, .level_o, .lim_we_i, .lim_wdata_i, .lim_rdata_o,
    .req_o, .ovf_o, .rd_err_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data();
    logic [31:0] l, r;
    if (q.size() == 0) return 32'h0;
    l = q[0][31:0];
    r = q[0][63:32];
    case (mode_i)
      2'd0:    return m_half ? r : l;
      2'd1:    return {r[15:0], l[15:0]};
      2'd2:    return {16'h0, r[7:0], l[7:0]};
      default: return l;
    endcase
  endfunction

  function automatic logic [4:0] exp_level();
    return 5'(2 * q.size() - int'(m_half));
  endfunction

  task automatic compare_all();
    string dtag;
    logic [4:0] lv;
    lv = exp_level();
    case (mode_i)
      2'd0: dtag = "R3 alternating data";
      2'd1: dtag = "R4 16-bit packed data";
      2'd2: dtag = "R5 byte packed data";
      default: dtag = "R6 single channel data";
    endcase
    if (q.size() == 0) dtag = "R9 empty data";
    chk("R1 level", 32'(level_o), 32'(lv));
    chk(dtag, rd_data_o, exp_data());
    chk("R7 request", 32'(req_o), 32'(lv > {m_lim[4:1], 1'b0}));
    chk("R8 limit readback", 32'(lim_rdata_o), 32'({m_lim[4:1], 1'b1}));
    chk("R2 overflow flag", 32'(ovf_o), 32'(m_ovf));
    chk("R9 read error flag", 32'(rd_err_o), 32'(m_err));
  endtask

  task automatic cycle(input bit w, input logic [31:0] l, input logic [31:0] r,
                       input bit rd, input bit lw, input logic [4:0] lv);
    int n;
    wr_valid_i = w; wr_left_i = l; wr_right_i = r;
    rd_en_i = rd; lim_we_i = lw; lim_wdata_i = lv;
    n = q.size();
    if (rd) begin
      if (n == 0) m_err = 1;
      else if (mode_i == 2'd0 && !m_half) m_half = 1;
      else begin
        void'(q.pop_front());
        m_half = 0;
      end
    end
    if (w) begin
      if (n == DEPTH) m_ovf = 1;
      else q.push_back({r, l});
    end
    if (lw) m_lim = lv;
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_ni = 1'b0;
    wr_valid_i = 0; rd_en_i = 0; lim_we_i = 0;
    mode_i = m;
    q.delete(); m_half = 0; m_ovf = 0; m_err = 0; m_lim = '0;
    @(negedge clk);
    chk("R10 reset level", 32'(level_o), 32'h0);
    chk("R10 reset request", 32'(req_o), 32'h0);
    chk("R10 reset flags", 32'({ovf_o, rd_err_o}), 32'h0);
    chk("R10 reset data", rd_data_o, 32'h0);
    chk("R10 reset limit", 32'(lim_rdata_o), 32'h1);
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  task automatic push(input bit rd);
    cycle(1, $urandom, $urandom, rd, 0, '0);
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      cycle(0, 0, 0, 0, 1, 5'd0);             // R7 limit 0
      push(0);                                 // R7 any data requests
      cycle(0, 0, 0, 1, 0, '0);                // R3/R6 partial or full read
      for (int i = 0; i < 10; i++) push(0);    // R2 overflow past 8 pairs
      push(1);                                 // R2 full push with read
      cycle(0, 0, 0, 0, 1, 5'd16);             // R7 limit 16 never requests
      cycle(0, 0, 0, 0, 1, 5'd7);              // R8 odd write reads back 7
      for (int i = 0; i < 20; i++) cycle(0, 0, 0, 1, 0, '0); // R9 drain past empty
      for (int i = 0; i < 400; i++) begin
        bit lw = ($urandom % 16) == 0;
        cycle(($urandom % 2) == 0, $urandom, $urandom, ($urandom % 3) == 0,
              lw, 5'($urandom % 18));
      end
      while (q.size() != 0) cycle(0, 0, 0, 1, 0, '0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule